// File: doc/BRIEF.md
# Signed Extended Word Divider

This unit performs signed divide-word-extended for an integer execution pipeline. It builds a 64-bit signed dividend by placing the low 32 bits of the first operand in the upper half, with zeros below. It divides that by the low 32 bits of the second operand, sign-extended. The quotient is truncated toward zero and must fit in a signed 32-bit value. The pipeline gets it back sign-extended to the register width.

Some cases have no valid answer: a zero divisor, the most-negative-by-minus-one pairing, or any quotient outside the signed 32-bit range. In each of these the result is forced to zero and overflow is raised. With the overflow-enable input set, the unit copies the overflow outcome into an OV bit and ORs it into a sticky SO bit. With it clear, both bits are left as they were.

Operation is multi-cycle, with a start/busy/done handshake. Operands are captured when start is accepted. The result and the flags stay put while done is high, until the next start is accepted.

Top module: `wordext_sdiv`

## Requirements
- R1: Only bits 31:0 of `opa` form the dividend, as dividend = {opa[31:0], 32'h0} read as signed 64-bit. Bits above 31 of `opa` and `opb` have no effect on the result.
- R2: The divisor is `opb[31:0]` sign-extended to 64 bits, so `opb[31:0]` = 32'hFFFFFFFD divides by -3.
- R3: Without overflow, `result` is the quotient truncated toward zero, sign-extended from bit 31 to the full register width.
- R4: A zero divisor raises overflow and gives `result` = 0 for any dividend.
- R5: Overflow is raised and `result` = 0 whenever the true quotient lies outside [-2^31, 2^31-1]. This includes dividend -2^63 with divisor -1, and quotient +2^31.
- R6: With `oe_en` captured high, overflow sets `ov_flag` and `so_flag`. No overflow clears `ov_flag` and leaves `so_flag` unchanged.
- R7: With `oe_en` captured low, `ov_flag` and `so_flag` keep their values whatever the outcome.
- R8: `start` is accepted only while `busy` is low, and operands are captured at that edge. `busy` is high from the next cycle. `done` rises on the 33rd rising edge after the accepting edge, at which point `busy` falls. `busy` and `done` are never high together.
- R9: While `done` is high, `result`, `ov_flag` and `so_flag` are stable until the next accepted `start`, which clears `done`. A `start` while `busy` is ignored.
- R10: After reset, `busy`, `done`, `result`, `ov_flag` and `so_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a divide; accepted when not busy |
| oe_en | input | 1 | Overflow-enable: allow OV/SO update for this divide |
| opa | input | REG_W | First operand; bits 31:0 become the dividend's upper half |
| opb | input | REG_W | Second operand; bits 31:0 form the divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Result and flags valid; held until next accepted start |
| result | output | REG_W | Sign-extended 32-bit quotient, zero on overflow |
| ov_flag | output | 1 | Overflow status bit |
| so_flag | output | 1 | Sticky summary-overflow bit |

## Verification
Every outcome is due on one edge: `done`, `result`, `ov_flag` and `so_flag` all update on the 33rd rising edge after the edge that accepted `start`, whatever the operands. The driver records that edge number when it pushes an expected item. The monitor samples only on falling edges. When it sees `done` rise it pops the item and checks the values and that exactly 33 edges have passed. On each later falling edge while `done` stays high, it checks that nothing has moved. Operands are scrambled, and a stray `start` is pulsed, during the run, so any late capture or re-trigger shows up as a wrong value or a wrong count.

// File: rtl/wxd_pkg.sv
package wxd_pkg;
  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // Magnitude of a two's-complement word; -2^31 maps to 2^31 unsigned.
  function automatic word_t abs_word(input word_t v);
    return v[WORD_W-1] ? (~v + word_t'(1)) : v;
  endfunction

  // Whether an unsigned quotient magnitude fits a signed word given its sign.
  function automatic logic quot_fits(input word_t mag, input logic neg);
    if (neg) return mag <= {1'b1, {(WORD_W-1){1'b0}}};
    return !mag[WORD_W-1];
  endfunction

  // Apply the sign to a magnitude.
  function automatic word_t apply_sign(input word_t mag, input logic neg);
    return neg ? (~mag + word_t'(1)) : mag;
  endfunction
endpackage

// File: rtl/wxd_prep.sv
module wxd_prep
  import wxd_pkg::*;
(
  input  word_t opa_word,
  input  word_t opb_word,
  output word_t mag_a,
  output word_t mag_b,
  output logic  neg,
  output logic  zero_div,
  output logic  early_ovf
);
  // Dividend is opa_word * 2^WORD_W, so quotient >= 2^WORD_W whenever
  // |a| >= |b|; only |a| < |b| needs the iteration.
  assign mag_a     = abs_word(opa_word);
  assign mag_b     = abs_word(opb_word);
  assign neg       = opa_word[WORD_W-1] ^ opb_word[WORD_W-1];
  assign zero_div  = (opb_word == '0);
  assign early_ovf = zero_div | (mag_a >= mag_b);
endmodule

// File: rtl/wxd_iter.sv
module wxd_iter
  import wxd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  word_t mag_a,
  input  word_t mag_b,
  input  logic  neg,
  input  logic  early,
  input  logic  oe,
  output logic  busy,
  output logic  fin,
  output word_t q_mag,
  output logic  neg_q,
  output logic  early_q,
  output logic  oe_q
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  word_t            rem_q;
  word_t            div_q;
  logic [WORD_W:0]  trial;
  logic [WORD_W:0]  diff;
  logic             take;
  word_t            rem_nx;

  // One restoring step: the dividend's low half is zero, so zeros shift in.
  always_comb begin
    trial  = {rem_q, 1'b0};
    diff   = trial - {1'b0, div_q};
    take   = (trial >= {1'b0, div_q});
    rem_nx = take ? diff[WORD_W-1:0] : trial[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      div_q   <= '0;
      q_mag   <= '0;
      neg_q   <= 1'b0;
      early_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_RUN;
          cnt_q   <= '0;
          rem_q   <= mag_a;
          div_q   <= mag_b;
          q_mag   <= '0;
          neg_q   <= neg;
          early_q <= early;
          oe_q    <= oe;
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          q_mag <= {q_mag[WORD_W-2:0], take};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign fin  = (st_q == ST_FIN);

  // R8: an accepted start turns busy on and restarts the step count.
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (cnt_q == '0));

  // R8: the finish cycle follows exactly the last of WORD_W steps.
  p_full_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(st_q == ST_RUN) && ($past(cnt_q) == LAST));

  // R3: restoring invariant, partial remainder stays below the divisor.
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && !early_q |-> rem_q < div_q);
endmodule

// File: rtl/wxd_xer.sv
module wxd_xer
  import wxd_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             fin,
  input  word_t            q_mag,
  input  logic             neg,
  input  logic             early,
  input  logic             oe,
  output logic             done,
  output logic [REG_W-1:0] result,
  output logic             ov_flag,
  output logic             so_flag
);
  localparam int unsigned EXT_W = REG_W - WORD_W;

  logic  ovf;
  word_t sq;

  assign ovf = early | !quot_fits(q_mag, neg);
  assign sq  = apply_sign(q_mag, neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      ov_flag <= 1'b0;
      so_flag <= 1'b0;
    end else if (accept) begin
      done <= 1'b0;
    end else if (fin) begin
      done   <= 1'b1;
      result <= ovf ? '0 : {{EXT_W{sq[WORD_W-1]}}, sq};
      if (oe) begin
        ov_flag <= ovf;
        so_flag <= so_flag | ovf;
      end
    end
  end

  // R4/R5: any overflow outcome leaves a zero result.
  p_zero_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin && ovf |=> (result == '0) && done);

  // R6: enabled overflow sets both status bits.
  p_ov_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && oe && ovf |=> ov_flag && so_flag);

  // R6: enabled clean divide clears OV and keeps SO.
  p_ov_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin && oe && !ovf |=> !ov_flag && (so_flag == $past(so_flag)));

  // R7: disabled update leaves both bits alone.
  p_flags_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !oe |=> $stable(ov_flag) && $stable(so_flag));

  // R9: outputs hold while done until the next accepted start.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !accept |=> done && $stable(result) && $stable(ov_flag) && $stable(so_flag));
endmodule

// File: rtl/wordext_sdiv.sv
module wordext_sdiv
  import wxd_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             oe_en,
  input  logic [REG_W-1:0] opa,
  input  logic [REG_W-1:0] opb,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] result,
  output logic             ov_flag,
  output logic             so_flag
);
  word_t mag_a, mag_b, q_mag;
  logic  neg, zero_div, early_ovf;
  logic  accept, fin, neg_q, early_q, oe_q;
  logic  unused_hi;

  assign accept    = start & ~busy;
  assign unused_hi = ^{opa[REG_W-1:WORD_W], opb[REG_W-1:WORD_W], zero_div};

  wxd_prep u_prep (
    .opa_word  (opa[WORD_W-1:0]),
    .opb_word  (opb[WORD_W-1:0]),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg       (neg),
    .zero_div  (zero_div),
    .early_ovf (early_ovf)
  );

  wxd_iter u_iter (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .neg     (neg),
    .early   (early_ovf),
    .oe      (oe_en),
    .busy    (busy),
    .fin     (fin),
    .q_mag   (q_mag),
    .neg_q   (neg_q),
    .early_q (early_q),
    .oe_q    (oe_q)
  );

  wxd_xer #(.REG_W(REG_W)) u_xer (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .fin     (fin),
    .q_mag   (q_mag),
    .neg     (neg_q),
    .early   (early_q),
    .oe      (oe_q),
    .done    (done),
    .result  (result),
    .ov_flag (ov_flag),
    .so_flag (so_flag)
  );

  // R8: the handshake never shows busy and done together.
  p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9: a start arriving while busy does not disturb the run.
  p_ignore_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !fin |=> busy);
endmodule

// File: tb/wordext_sdiv_tb.sv
module wordext_sdiv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        oe_en = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        busy, done, ov_flag, so_flag;
  logic [63:0] result;

  always #2.5 clk = ~clk;

  wordext_sdiv u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .oe_en(oe_en),
    .opa(opa), .opb(opb), .busy(busy), .done(done),
    .result(result), .ov_flag(ov_flag), .so_flag(so_flag)
  );

  typedef struct {
    logic [63:0] res;
    logic        ov;
    logic        so;
    int          t0;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  logic m_ov = 1'b0, m_so = 1'b0;
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Independent reference: 64-bit signed division with range check.
  task automatic model(input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r, output logic ov);
    longint dd, dv, q;
    dd = $signed({a[31:0], 32'h0});
    dv = longint'($signed(b[31:0]));
    r  = '0;
    if (dv == 0 || (dv == -1 && dd == 64'sh8000_0000_0000_0000)) ov = 1'b1;
    else begin
      q  = dd / dv;
      ov = (q < -64'sd2147483648) || (q > 64'sd2147483647);
      if (!ov) r = q;
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b,
                       input logic oe, input string tag, input bit poke);
    exp_t it;
    logic ov;
    @(negedge clk);
    while (busy) @(negedge clk);
    model(a, b, it.res, ov);
    if (oe) begin
      m_ov = ov;
      m_so = m_so | ov;
    end
    it.ov  = m_ov;
    it.so  = m_so;
    it.tag = tag;
    it.t0  = cyc + 1;
    sbq.push_back(it);
    opa = a; opb = b; oe_en = oe; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: operands after the accepting edge must not matter.
    opa = {$urandom, $urandom}; opb = {$urandom, $urandom}; oe_en = ~oe;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;   // R9: start while busy is ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop on the rise of done, then check hold while done stays.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !prev_done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 64'h1, 64'h0);
        end else begin
          cur = sbq.pop_front();
          check(result == cur.res, cur.tag, "result", result, cur.res);
          check(ov_flag == cur.ov, cur.ov ? "R6" : "R7", "ov_flag", 64'(ov_flag), 64'(cur.ov));
          check(so_flag == cur.so, "R6", "so_flag", 64'(so_flag), 64'(cur.so));
          check(cyc - cur.t0 == 33, "R8", "latency", 64'(cyc - cur.t0), 64'd33);
          check(!busy, "R8", "busy with done", 64'(busy), 64'h0);
        end
      end else if (done) begin
        check(result == cur.res && ov_flag == cur.ov && so_flag == cur.so,
              "R9", "hold", result, cur.res);
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && result == '0 && !ov_flag && !so_flag,
          "R10", "reset state", {59'h0, busy, done, ov_flag, so_flag, |result}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(64'h1, 64'h3, 1'b1, "R3", 1'b0);                       // 0x55555555
    issue(64'hFFFF_FFFF, 64'h3, 1'b1, "R3", 1'b0);               // trunc toward zero
    issue(64'hDEAD_BEEF_0000_0001, 64'h1234_5678_0000_0003, 1'b0, "R1", 1'b0);
    issue(64'h1, 64'hFFFF_FFFD, 1'b0, "R2", 1'b0);               // divide by -3
    issue(64'h1, 64'hFFFF_FFFE, 1'b1, "R3", 1'b0);               // exactly -2^31
    issue(64'h5, 64'h0, 1'b0, "R4", 1'b0);                       // flags untouched
    issue(64'h0, 64'h0, 1'b1, "R4", 1'b0);
    issue(64'h1, 64'h3, 1'b1, "R6", 1'b0);                       // OV clears, SO stays
    issue(64'h8000_0000, 64'hFFFF_FFFF, 1'b1, "R5", 1'b0);       // min / -1
    issue(64'h1, 64'h2, 1'b1, "R5", 1'b0);                       // +2^31
    issue(64'h7FFF_FFFF, 64'h8000_0000, 1'b0, "R5", 1'b0);
    issue(64'h8000_0000, 64'h7FFF_FFFF, 1'b0, "R5", 1'b0);
    issue(64'h0, 64'h7FFF_FFFF, 1'b1, "R3", 1'b1);               // zero dividend, poke
    issue(64'h3, 64'h7FFF_FFFF, 1'b1, "R8", 1'b1);
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 2 == 0) a[31:0] = $signed(a[31:0]) >>> (i % 31);
      issue(a, b, 1'(i % 3 != 0), "R3", 1'b0);
    end

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R8", "pending items", 64'(sbq.size()), 64'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule